// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The fetch stage presents the address of the instruction it is fetching on a lookup channel. In the same cycle the block answers with a taken or not-taken guess. Later, the execute stage reports the branch's real address and outcome on an update port, and the block trains its tables with that outcome. All state is held in flip-flops.

One elaboration-time parameter selects how the tables are organised:

- **bimodal:** a single table of 2-bit counters, indexed by address.
- **local two-level:** a per-address table of history shift registers selects a counter.
- **global two-level:** one history register, shared by every branch, selects a counter.
- **global-xor:** the shared history is XORed with address bits to select a counter.

Every organisation uses a counter table of 2^HIST_W entries. Addresses are byte addresses of 32-bit words, so the two lowest address bits never take part in indexing.

The lookup channel is valid/ready, and it passes through with no storage. A response is valid exactly when a request is valid. A request is accepted only when the consumer is ready for the response, so back-pressure on the response stalls the request in the same cycle. The update port is plain: every cycle with `upd_valid` high trains the tables once.

Top module: `bpred_dir`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and every history register holds zero, so every lookup predicts not-taken until the first update.
- R2: The prediction is the most significant bit of the selected 2-bit counter. It is given combinationally, in the same cycle as the lookup.
- R3: An update moves the selected counter one step up when the branch was taken and one step down when it was not. The counter saturates at 3 and at 0.
- R4: In the bimodal organisation (KIND = 0), the counter index is address bits [HIST_W+1:2].
- R5: In the local organisation (KIND = 1), address bits [SEL_W+1:2] pick one of 2^SEL_W history registers. That register's value is the counter index.
- R6: In the global organisation (KIND = 2), a single history register is the counter index, and updates from every address shift into it.
- R7: In the global-xor organisation (KIND = 3), the counter index is the global history XOR address bits [HIST_W+1:2].
- R8: On an update, the selected history register shifts left and takes the outcome (1 = taken) into bit 0. Without `upd_valid`, no table changes.
- R9: An update uses the history and counter values held before its clock edge. A lookup in the same cycle as an update to the same entry returns the old value.
- R10: `rsp_valid` equals `req_valid`, and `req_ready` equals `rsp_ready`.
- R11: Address bits [1:0] have no effect on lookup or update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted (follows rsp_ready) |
| req_pc | input | PC_W | Fetch address to predict |
| rsp_valid | output | 1 | Prediction valid |
| rsp_ready | input | 1 | Consumer ready for prediction |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved branch report valid |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives the same stimulus into all four organisations at once and predicts each output from its own table model.

The corner cases it targets, and what a faulty design would show:

- **Saturation:** long runs of one outcome followed by a single opposite outcome. A counter that wraps instead of saturating would flip its prediction at once.
- **Same-cycle hazard:** a lookup and an update to the same entry in one cycle. A design that forwards the new value, or misorders the history shift against the counter write, would disagree with the old-value rule.
- **Alternating pattern:** a taken/not-taken pattern on one branch separates local from global history. A design with the history bit order wrong would never learn the pattern.
- **Ignored address bits:** addresses that differ only in bits [1:0]. A design that indexes with those bits would train the wrong entries.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    PK_BIMODAL = 2'd0,
    PK_LOCAL   = 2'd1,
    PK_GLOBAL  = 2'd2,
    PK_GSHARE  = 2'd3
  } pred_kind_e;

  localparam int unsigned WORD_OFS = 2;

  localparam logic [1:0] CNT_RESET = 2'b01;

  function automatic logic [1:0] sat_step(input logic [1:0] cnt, input logic taken);
    logic [1:0] nxt;
    nxt = cnt;
    if (taken && cnt != 2'b11) nxt = cnt + 2'b01;
    else if (!taken && cnt != 2'b00) nxt = cnt - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/bpred_hist.sv
module bpred_hist
  import bpred_pkg::*;
#(
  parameter pred_kind_e KIND = PK_LOCAL,
  parameter int unsigned PC_W = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   rd_pc,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_taken,
  output logic [HIST_W-1:0] wr_hist
);
  localparam int unsigned ENTRIES = 1 << SEL_W;

  generate
    if (KIND == PK_LOCAL) begin : g_local
      logic [HIST_W-1:0] table_q [ENTRIES];
      logic [SEL_W-1:0] rd_sel, wr_sel;
      logic unused_pc;

      assign rd_sel = rd_pc[WORD_OFS +: SEL_W];
      assign wr_sel = wr_pc[WORD_OFS +: SEL_W];
      assign unused_pc = ^{rd_pc, wr_pc};
      assign rd_hist = table_q[rd_sel];
      assign wr_hist = table_q[wr_sel];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
        end else if (wr_en) begin
          table_q[wr_sel] <= {table_q[wr_sel][HIST_W-2:0], wr_taken};
        end
      end
    end else if (KIND == PK_GLOBAL || KIND == PK_GSHARE) begin : g_global
      logic [HIST_W-1:0] ghist_q;
      logic unused_pc;

      assign unused_pc = ^{rd_pc, wr_pc};
      assign rd_hist = ghist_q;
      assign wr_hist = ghist_q;

      always_ff @(posedge clk) begin
        if (!rst_n) ghist_q <= '0;
        else if (wr_en) ghist_q <= {ghist_q[HIST_W-2:0], wr_taken};
      end
    end else begin : g_none
      logic unused_in;

      assign unused_in = ^{clk, rst_n, rd_pc, wr_en, wr_pc, wr_taken};
      assign rd_hist = '0;
      assign wr_hist = '0;
    end
  endgenerate

endmodule

// File: rtl/bpred_index.sv
module bpred_index
  import bpred_pkg::*;
#(
  parameter pred_kind_e KIND = PK_LOCAL,
  parameter int unsigned PC_W = 32,
  parameter int unsigned HIST_W = 6
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);
  logic [HIST_W-1:0] pc_bits;
  logic unused_pc;

  assign pc_bits = pc[WORD_OFS +: HIST_W];
  assign unused_pc = ^pc;

  generate
    if (KIND == PK_BIMODAL) begin : g_bim
      logic unused_hist;
      assign unused_hist = ^hist;
      assign idx = pc_bits;
    end else if (KIND == PK_GSHARE) begin : g_xor
      assign idx = hist ^ pc_bits;
    end else begin : g_hist
      assign idx = hist;
    end
  endgenerate

endmodule

// File: rtl/bpred_pht.sv
module bpred_pht
  import bpred_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [1:0] cnt_q [ENTRIES];
  logic [1:0] rd_cnt;

  assign rd_cnt = cnt_q[rd_idx];
  assign rd_taken = rd_cnt[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CNT_RESET;
    end else if (wr_en) begin
      cnt_q[wr_idx] <= sat_step(cnt_q[wr_idx], wr_taken);
    end
  end

endmodule

// File: rtl/bpred_dir.sv
module bpred_dir
  import bpred_pkg::*;
#(
  parameter pred_kind_e KIND = PK_LOCAL,
  parameter int unsigned PC_W = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned HIST_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  logic [HIST_W-1:0] rd_hist, wr_hist;
  logic [HIST_W-1:0] rd_idx, wr_idx;

  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;

  bpred_hist #(.KIND(KIND), .PC_W(PC_W), .SEL_W(SEL_W), .HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pc    (req_pc),
    .rd_hist  (rd_hist),
    .wr_en    (upd_valid),
    .wr_pc    (upd_pc),
    .wr_taken (upd_taken),
    .wr_hist  (wr_hist)
  );

  bpred_index #(.KIND(KIND), .PC_W(PC_W), .HIST_W(HIST_W)) u_rd_index (
    .pc   (req_pc),
    .hist (rd_hist),
    .idx  (rd_idx)
  );

  bpred_index #(.KIND(KIND), .PC_W(PC_W), .HIST_W(HIST_W)) u_wr_index (
    .pc   (upd_pc),
    .hist (wr_hist),
    .idx  (wr_idx)
  );

  bpred_pht #(.IDX_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_taken (rsp_taken),
    .wr_en    (upd_valid),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken)
  );

endmodule

// File: rtl/bpred_dir_chk.sv
module bpred_dir_chk
  import bpred_pkg::*;
#(
  parameter pred_kind_e KIND = PK_LOCAL,
  parameter int unsigned PC_W = 32,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned HIST_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PC_W-1:0] req_pc,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_taken,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken
);
  logic unused_sel;
  assign unused_sel = (SEL_W == 0);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == req_valid);

  assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == rsp_ready);

  assert_first_not_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_taken);

  // R8: with no update, a held address keeps its prediction
  assert_hold_without_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid) ##1 $stable(req_pc) |-> $stable(rsp_taken));

  generate
    if (KIND == PK_BIMODAL) begin : g_bim
      logic same_entry;
      assign same_entry = (upd_pc[WORD_OFS +: HIST_W] == req_pc[WORD_OFS +: HIST_W]);

      assert_taken_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && rsp_taken && same_entry) ##1 $stable(req_pc) |-> rsp_taken);

      assert_not_taken_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !rsp_taken && same_entry) ##1 $stable(req_pc) |-> !rsp_taken);
    end
  endgenerate

endmodule

bind bpred_dir bpred_dir_chk #(.KIND(KIND), .PC_W(PC_W), .SEL_W(SEL_W), .HIST_W(HIST_W)) u_chk (.*);

// File: tb/sim_bpred_dir.sv
module sim_bpred_dir;
  import bpred_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int SEL_W = 4;
  localparam int HIST_W = 6;
  localparam int NCNT = 1 << HIST_W;
  localparam int NSEL = 1 << SEL_W;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic rsp_ready = 1;
  logic [PC_W-1:0] req_pc = '0;
  logic upd_valid = 0;
  logic [PC_W-1:0] upd_pc = '0;
  logic upd_taken = 0;

  logic [3:0] rdy, vld, tkn;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bit index of each vector = predictor kind encoding
  bpred_dir #(.KIND(PK_LOCAL)) u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_pc(req_pc), .rsp_valid(vld[1]), .rsp_ready(rsp_ready), .rsp_taken(tkn[1]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
  bpred_dir #(.KIND(PK_BIMODAL)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_pc(req_pc), .rsp_valid(vld[0]), .rsp_ready(rsp_ready), .rsp_taken(tkn[0]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
  bpred_dir #(.KIND(PK_GLOBAL)) u2 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[2]),
    .req_pc(req_pc), .rsp_valid(vld[2]), .rsp_ready(rsp_ready), .rsp_taken(tkn[2]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
  bpred_dir #(.KIND(PK_GSHARE)) u3 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[3]),
    .req_pc(req_pc), .rsp_valid(vld[3]), .rsp_ready(rsp_ready), .rsp_taken(tkn[3]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // reference model
  logic [1:0] m_cnt [4][NCNT];
  logic [HIST_W-1:0] m_bht [NSEL];
  logic [HIST_W-1:0] m_gh;

  function automatic logic [HIST_W-1:0] m_idx(input int k, input logic [PC_W-1:0] pc);
    logic [HIST_W-1:0] pb;
    pb = pc[2 +: HIST_W];
    case (k)
      0: return pb;
      1: return m_bht[pc[2 +: SEL_W]];
      2: return m_gh;
      default: return m_gh ^ pb;
    endcase
  endfunction

  function automatic logic [3:0] m_predict(input logic [PC_W-1:0] pc);
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = m_cnt[k][m_idx(k, pc)][1];
    return v;
  endfunction

  task automatic m_update(input logic [PC_W-1:0] pc, input logic t);
    for (int k = 0; k < 4; k++) begin
      logic [HIST_W-1:0] ix;
      ix = m_idx(k, pc);
      if (t && m_cnt[k][ix] != 2'b11) m_cnt[k][ix] = m_cnt[k][ix] + 2'b01;
      else if (!t && m_cnt[k][ix] != 2'b00) m_cnt[k][ix] = m_cnt[k][ix] - 2'b01;
    end
    m_bht[pc[2 +: SEL_W]] = {m_bht[pc[2 +: SEL_W]][HIST_W-2:0], t};
    m_gh = {m_gh[HIST_W-2:0], t};
  endtask

  task automatic m_reset();
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < NCNT; i++) m_cnt[k][i] = 2'b01;
    for (int i = 0; i < NSEL; i++) m_bht[i] = '0;
    m_gh = '0;
  endtask

  // scoreboard
  logic [3:0] exp_q [$];
  string tag_q [$];

  task automatic step(input logic rv, input logic [PC_W-1:0] pc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut, input string tag);
    @(negedge clk);
    req_valid = rv;
    req_pc = pc;
    upd_valid = uv;
    upd_pc = upc;
    upd_taken = ut;
    if (rv && rsp_ready) begin
      exp_q.push_back(m_predict(pc));
      tag_q.push_back(tag);
    end
    if (uv) m_update(upc, ut);
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && vld[1] && rsp_ready) begin
      logic [3:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected response actual=%b expected=none", tkn);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (tkn !== e) begin
          errors++;
          $display("FAIL %s: pc=%h actual=%b expected=%b (bit=kind)", t, req_pc, tkn, e);
        end
      end
    end
  end

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, 1'b0, "idle");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [15:0] lfsr;

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 R2: reset state predicts not-taken everywhere
    for (int i = 0; i < 8; i++) step(1'b1, 32'h40 * i, 1'b0, '0, 1'b0, "R1");

    // R10: handshake pass-through under back-pressure
    step(1'b1, 32'h100, 1'b0, '0, 1'b0, "R10");
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1;
    #1;
    checks++;
    if (rdy !== 4'b0000 || vld !== 4'b1111) begin
      errors++;
      $display("FAIL R10: ready=%b valid=%b expected ready=0000 valid=1111", rdy, vld);
    end
    req_valid = 0;
    #1;
    checks++;
    if (vld !== 4'b0000) begin
      errors++;
      $display("FAIL R10: valid=%b expected=0000", vld);
    end
    rsp_ready = 1;

    // R3 R4: train one branch taken, saturate, one contrary outcome
    for (int i = 0; i < 5; i++) step(1'b1, 32'h100, 1'b1, 32'h100, 1'b1, "R3");
    step(1'b1, 32'h100, 1'b0, '0, 1'b0, "R4");
    step(1'b1, 32'h100, 1'b1, 32'h100, 1'b0, "R3");
    step(1'b1, 32'h100, 1'b0, '0, 1'b0, "R3");
    for (int i = 0; i < 5; i++) step(1'b1, 32'h100, 1'b1, 32'h100, 1'b0, "R3");
    step(1'b1, 32'h100, 1'b0, '0, 1'b0, "R3");

    // R9: lookup and update on the same entry in one cycle
    step(1'b1, 32'h180, 1'b1, 32'h180, 1'b1, "R9");
    step(1'b1, 32'h180, 1'b1, 32'h180, 1'b1, "R9");
    step(1'b1, 32'h180, 1'b0, '0, 1'b0, "R9");

    // R5 R8: alternating pattern on one branch
    for (int i = 0; i < 24; i++) step(1'b1, 32'h204, 1'b1, 32'h204, i[0], "R5");

    // R6: interleaved branches share one history
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 32'h310, 1'b1, 32'h310, 1'b1, "R6");
      step(1'b1, 32'h520, 1'b1, 32'h520, 1'b0, "R6");
    end

    // R11: low address bits ignored
    for (int i = 0; i < 4; i++) step(1'b1, 32'h400, 1'b1, 32'h403, 1'b1, "R11");
    step(1'b1, 32'h402, 1'b0, '0, 1'b0, "R11");

    // R7 R8: pseudo-random traffic, some cycles without update
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], {22'd0, lfsr[9:1], 1'b0}, lfsr[11], {22'd0, lfsr[15:7], 1'b0},
           lfsr[3] | lfsr[5], "R7");
    end

    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule